// File: doc/BRIEF.md
# Supply Check Scheduler and Battery Classifier

This block sets the times at which the supply comparators are read, and it turns each reading into a battery mode. It runs from the 32768 Hz watch clock. One down-counter gives a sparse schedule. The first check comes about 30 ms after reset is released. After that, checks come once a minute in normal operation. The two test selections shorten the interval to 125 ms or 31.25 ms.

Each check raises `sample_o` for one clock cycle. This strobe also powers the comparators. The comparator outputs are read at the end of the strobe cycle, which gives them that cycle to settle. The result goes into a registered two-bit mode that the motor driver uses. This mode holds its value until the next check.

Top module: `supply_check`

## Requirements
- R1: While `rst_i` is high, `sample_o` is 0 and `mode_o` is 2'b00 (silver-oxide). After release, the first strobe is high in the cycle after rising edge number FIRST_DLY, counted from release. The default FIRST_DLY is 983.
- R2: `sample_o` is high for exactly one clock cycle each time.
- R3: With `tsel_i` at 2'b00 or 2'b11 (normal), consecutive strobes are MINUTE_CYC edges apart. The default MINUTE_CYC is 1966080.
- R4: With `tsel_i` = 2'b01, strobes are T1_CYC edges apart (default 4096). With `tsel_i` = 2'b10, they are T2_CYC edges apart (default 1024).
- R5: Any change of `tsel_i` cancels the pending check, including the first one after reset. The next strobe comes at the interval of the new selection, counted from the edge that first sees the new value.
- R6: On the edge that ends a strobe cycle, `mode_o` loads a new value from the comparators: `veol_i`=1 gives 2'b10 (end of life), `vlith_i`=1 with `veol_i`=0 gives 2'b01 (lithium), and both low gives 2'b00 (silver-oxide). If both are high, end of life wins.
- R7: Between strobes, `mode_o` keeps its value and changes on the comparator inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 32768 Hz clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tsel_i | input | 2 | Interval select: 00/11 normal, 01 test 125 ms, 10 test 31.25 ms |
| vlith_i | input | 1 | Comparator: supply at or above lithium threshold |
| veol_i | input | 1 | Comparator: supply at or below end-of-life threshold |
| sample_o | output | 1 | One-cycle check strobe and comparator enable |
| mode_o | output | 2 | Registered battery mode |

## Verification
The assertions check the following on every cycle:
- the strobe is a single cycle wide;
- no strobe follows a change of selection;
- the counter stays in range;
- the mode is never the unused code;
- the mode holds outside checks;
- each comparator combination maps to the correct mode on the edge after a strobe.

Only the bench scenarios can show the absolute placement of the strobes. This covers the first-check delay, each interval length, the restart when the selection changes in the middle of an interval, and a second reset in the middle of a run.

// File: rtl/sck_pkg.sv
package sck_pkg;

  typedef enum logic [1:0] {
    MODE_SILVER = 2'b00,
    MODE_LITH   = 2'b01,
    MODE_EOL    = 2'b10
  } batt_mode_e;

  typedef enum logic [1:0] {
    TS_NORMAL = 2'b00,
    TS_T125   = 2'b01,
    TS_T31    = 2'b10,
    TS_ALT    = 2'b11
  } tsel_e;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sck_interval.sv
module sck_interval
  import sck_pkg::*;
#(
  parameter int MINUTE_CYC = 1966080,
  parameter int T1_CYC     = 4096,
  parameter int T2_CYC     = 1024,
  parameter int CW         = 21
) (
  input  logic [1:0]    tsel_i,
  output logic [CW-1:0] reload_o
);

  // reload value is interval minus one: the counter's zero cycle counts too
  always_comb begin
    case (tsel_e'(tsel_i))
      TS_T125: reload_o = CW'(T1_CYC - 1);
      TS_T31:  reload_o = CW'(T2_CYC - 1);
      default: reload_o = CW'(MINUTE_CYC - 1);
    endcase
  end

endmodule

// File: rtl/sck_timer.sv
module sck_timer #(
  parameter int FIRST_DLY = 983,
  parameter int MAX_CYC   = 1966080,
  parameter int CW        = 21
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [1:0]    tsel_i,
  input  logic [CW-1:0] reload_i,
  output logic          strobe_o
);

  logic [CW-1:0] cnt_q;
  logic [1:0]    tsel_q;
  logic          strobe_q;
  logic          sel_change;

  assign sel_change = (tsel_i != tsel_q);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q    <= CW'(FIRST_DLY - 1);
      tsel_q   <= tsel_i;
      strobe_q <= 1'b0;
    end else begin
      tsel_q <= tsel_i;
      if (sel_change) begin
        cnt_q    <= reload_i;
        strobe_q <= 1'b0;
      end else if (cnt_q == '0) begin
        cnt_q    <= reload_i;
        strobe_q <= 1'b1;
      end else begin
        cnt_q    <= cnt_q - CW'(1);
        strobe_q <= 1'b0;
      end
    end
  end

  assign strobe_o = strobe_q;

  // R2
  strobe_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    strobe_q |=> !strobe_q);

  // R5
  sel_restart_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    sel_change |=> !strobe_q);

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= CW'(MAX_CYC - 1));

endmodule

// File: rtl/sck_classify.sv
module sck_classify
  import sck_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       strobe_i,
  input  logic       vlith_i,
  input  logic       veol_i,
  output logic [1:0] mode_o
);

  batt_mode_e mode_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mode_q <= MODE_SILVER;
    end else if (strobe_i) begin
      if (veol_i)       mode_q <= MODE_EOL;
      else if (vlith_i) mode_q <= MODE_LITH;
      else              mode_q <= MODE_SILVER;
    end
  end

  assign mode_o = mode_q;

  // R7
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !strobe_i |=> $stable(mode_q));

  // R6
  eol_wins_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (strobe_i && veol_i) |=> (mode_o == 2'b10));

  // R6
  lith_sel_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (strobe_i && vlith_i && !veol_i) |=> (mode_o == 2'b01));

  // R6
  silver_sel_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (strobe_i && !vlith_i && !veol_i) |=> (mode_o == 2'b00));

  // R6
  mode_code_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    mode_o != 2'b11);

endmodule

// File: rtl/supply_check.sv
module supply_check
  import sck_pkg::*;
#(
  parameter int FIRST_DLY  = 983,
  parameter int MINUTE_CYC = 1966080,
  parameter int T1_CYC     = 4096,
  parameter int T2_CYC     = 1024
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [1:0] tsel_i,
  input  logic       vlith_i,
  input  logic       veol_i,
  output logic       sample_o,
  output logic [1:0] mode_o
);

  localparam int MAX_CYC = max_of4(FIRST_DLY, MINUTE_CYC, T1_CYC, T2_CYC);
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic [CW-1:0] reload;
  logic          strobe;

  sck_interval #(
    .MINUTE_CYC (MINUTE_CYC),
    .T1_CYC     (T1_CYC),
    .T2_CYC     (T2_CYC),
    .CW         (CW)
  ) u_interval (
    .tsel_i   (tsel_i),
    .reload_o (reload)
  );

  sck_timer #(
    .FIRST_DLY (FIRST_DLY),
    .MAX_CYC   (MAX_CYC),
    .CW        (CW)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .tsel_i   (tsel_i),
    .reload_i (reload),
    .strobe_o (strobe)
  );

  sck_classify u_classify (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .strobe_i (strobe),
    .vlith_i  (vlith_i),
    .veol_i   (veol_i),
    .mode_o   (mode_o)
  );

  assign sample_o = strobe;

endmodule

// File: tb/supply_check_test.sv
module supply_check_test;

  localparam int FIRST = 983;
  localparam int MIN   = 5000;
  localparam int T1    = 4096;
  localparam int T2    = 1024;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] tsel = 2'b00;
  logic       vlith = 1'b1;
  logic       veol = 1'b0;
  logic       sample_o;
  logic [1:0] mode_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  string cur_req = "R1";

  int         exp_cyc[$];
  logic [1:0] exp_mode[$];
  bit         mode_pend = 1'b0;
  int         pend_at   = 0;
  logic [1:0] pend_mode = 2'b00;

  always #2 clk = ~clk;

  supply_check #(
    .FIRST_DLY  (FIRST),
    .MINUTE_CYC (MIN),
    .T1_CYC     (T1),
    .T2_CYC     (T2)
  ) uut (
    .clk_i    (clk),
    .rst_i    (rst),
    .tsel_i   (tsel),
    .vlith_i  (vlith),
    .veol_i   (veol),
    .sample_o (sample_o),
    .mode_o   (mode_o)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cyc %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_check(input int at, input logic [1:0] m);
    exp_cyc.push_back(at);
    exp_mode.push_back(m);
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // monitor: pops expected strobes and the mode that must follow each one
  always @(negedge clk) begin
    if (!rst) begin
      if (sample_o) begin
        if (exp_cyc.size() == 0) begin
          chk(1'b0, cur_req, cyc, -1);
        end else begin
          int         e;
          logic [1:0] m;
          e = exp_cyc.pop_front();
          m = exp_mode.pop_front();
          chk(cyc == e, cur_req, cyc, e);
          mode_pend = 1'b1;
          pend_at   = cyc + 1;
          pend_mode = m;
        end
      end
      if (mode_pend && cyc == pend_at) begin
        mode_pend = 1'b0;
        chk(mode_o == pend_mode, "R6", int'(mode_o), int'(pend_mode));
        chk(sample_o == 1'b0, "R2", int'(sample_o), 0);
      end
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(sample_o == 1'b0, "R1", int'(sample_o), 0);
    chk(mode_o == 2'b00, "R1", int'(mode_o), 0);
    rst = 1'b0;
    cur_req = "R1";
    expect_check(FIRST, 2'b01);
    wait_to(900);
    chk(mode_o == 2'b00, "R1", int'(mode_o), 0);

    // normal interval, R3
    wait_to(FIRST + 2);
    cur_req = "R3";
    expect_check(FIRST + MIN, 2'b10);
    expect_check(FIRST + 2 * MIN, 2'b00);
    wait_to(3000);
    vlith = 1'b0; veol = 1'b1;
    wait_to(5900);
    chk(mode_o == 2'b01, "R7", int'(mode_o), 1);
    wait_to(8000);
    vlith = 1'b0; veol = 1'b0;
    wait_to(10900);
    chk(mode_o == 2'b10, "R7", int'(mode_o), 2);

    // test 1 selection: restart R5, then R4
    wait_to(12000);
    tsel = 2'b01;
    cur_req = "R5";
    expect_check(12001 + T1, 2'b00);
    expect_check(12001 + 2 * T1, 2'b01);
    wait_to(16100);
    cur_req = "R4";
    wait_to(17000);
    vlith = 1'b1;

    // test 2 selection, both comparators high -> end of life
    wait_to(21000);
    tsel = 2'b10;
    vlith = 1'b1; veol = 1'b1;
    cur_req = "R5";
    expect_check(21001 + T2, 2'b10);
    expect_check(21001 + 2 * T2, 2'b00);
    expect_check(21001 + 3 * T2, 2'b00);
    wait_to(22100);
    cur_req = "R4";
    vlith = 1'b0; veol = 1'b0;

    // code 11 behaves as normal
    wait_to(25000);
    tsel = 2'b11;
    cur_req = "R5";
    expect_check(25001 + MIN, 2'b01);
    wait_to(26000);
    vlith = 1'b1;
    wait_to(30100);
    chk(mode_o == 2'b01, "R3", int'(mode_o), 1);

    // second reset in mid-run
    rst = 1'b1;
    mode_pend = 1'b0;
    repeat (3) @(negedge clk);
    chk(sample_o == 1'b0, "R1", int'(sample_o), 0);
    chk(mode_o == 2'b00, "R1", int'(mode_o), 0);
    rst = 1'b0;
    cur_req = "R1";
    expect_check(FIRST, 2'b01);
    wait_to(FIRST + 20);

    chk(exp_cyc.size() == 0, "R3", exp_cyc.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule